// File: doc/BRIEF.md
# Two-Level Page Table Walker with Translation Cache

This block turns a 20-bit virtual address into a 20-bit physical address for a memory system with 64 KB pages. A four-slot fully associative translation cache sits in front of a hardware walker. A request whose virtual page is already cached is answered one cycle after it is accepted and makes no memory access. A request that misses starts a walk through a two-level table held in byte-addressed memory. The walker first reads a 4-byte level-1 entry, then a 4-byte level-2 entry, through a simple request/response port. It then writes the new mapping into the cache and returns the physical address.

The level-1 table is found through a base register that resets to 0x01000 and can be reloaded from a dedicated write port. A level-1 entry holds the full physical base address of a level-2 table. A level-2 entry carries the physical page number in bits 19:16, and its low 16 bits are status bits that the walker ignores. The page offset passes through unchanged.

Top module: `pagewalk_xlate`

## Requirements
- R1: After reset, `reqReady` is 1, `respValid` is 0, `memReqValid` is 0, and the table base register holds 0x01000.
- R2: A virtual address splits as follows: bits 19:18 are the level-1 index, bits 17:16 are the level-2 index, and bits 15:0 are the page offset. The virtual page number is bits 19:16.
- R3: The first memory read of a walk goes to the table base plus four times the level-1 index.
- R4: The second memory read of a walk goes to bits 19:0 of the returned level-1 entry plus four times the level-2 index. Entry bits 31:20 are ignored.
- R5: The physical page number is taken from bits 19:16 of the level-2 entry. Bits 15:0 and bits 31:20 of that entry have no effect on the result.
- R6: The returned physical address is the 4-bit physical page number in bits 19:16, followed by the request's 16-bit offset.
- R7: On a cache hit, `respValid` is 1 in the cycle right after the request is accepted, and no memory read is issued.
- R8: A miss issues exactly two memory reads, each a single-cycle `memReqValid` pulse. Only one read is outstanding at a time, and the second read is issued only after `memRspValid` returns data for the first.
- R9: An empty cache slot is always filled before an occupied slot, lowest free index first. After a walk, the new mapping hits on the next request.
- R10: Once all four slots are occupied, each further fill replaces slots in round-robin order, starting with slot 0 after reset.
- R11: A cycle with `baseWe` at 1 loads `baseData` into the table base register, and later walks use the new base.
- R12: `reqReady` is 0 from the cycle after a missing request is accepted until the walk's response is delivered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Translation request present |
| reqReady | output | 1 | Block can accept a request this cycle |
| reqVaddr | input | 20 | Virtual address to translate |
| baseWe | input | 1 | Load strobe for the table base register |
| baseData | input | 20 | New level-1 table base address |
| respValid | output | 1 | One-cycle pulse, translation result valid |
| respPaddr | output | 20 | Translated physical address |
| memReqValid | output | 1 | One-cycle memory read request |
| memReqAddr | output | 20 | Byte address of the 4-byte entry to read |
| memRspValid | input | 1 | Read data valid |
| memRspData | input | 32 | Read data (one table entry) |

## Verification
Cache state only becomes visible at the ports through two things. One is the number of memory reads that follow a request. The other is whether the response arrives after one cycle or after a walk. A wrong slot choice therefore shows up as a hit or a miss on the wrong virtual page, several requests after the bad fill. The eviction sequences are built to expose that within one pass around the round-robin order. A wrong walk address or a wrong entry field shows up at once, either on `memReqAddr` during the same walk or in the physical page bits of the response that ends it.

// File: rtl/pw_pkg.sv
package pw_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_L1REQ,
    ST_L1WAIT,
    ST_L2REQ,
    ST_L2WAIT
  } walkState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic latchReq;   // capture incoming virtual address
    logic hitResp;    // answer from the cache this cycle
    logic selL2;      // memory address mux selects level-2 entry
    logic takeL1;     // capture level-1 entry as next table base
    logic takeL2;     // capture level-2 entry, fill cache, respond
  } ctrlStrobe_t;

endpackage

// File: rtl/pw_tlb.sv
module pw_tlb #(
  parameter int ENTRIES = 4,
  parameter int VPN_W   = 4,
  parameter int PPN_W   = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [VPN_W-1:0] lookVpn,
  output logic             hit,
  output logic [PPN_W-1:0] hitPpn,
  input  logic             fillEn,
  input  logic [VPN_W-1:0] fillVpn,
  input  logic [PPN_W-1:0] fillPpn
);
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ENTRIES - 1);

  logic [ENTRIES-1:0] slotValid;
  logic [ENTRIES-1:0] slotMatch;
  logic [VPN_W-1:0]   slotVpn [ENTRIES];
  logic [PPN_W-1:0]   slotPpn [ENTRIES];
  logic [IDX_W-1:0]   rrPtr;
  logic [IDX_W-1:0]   freeIdx;
  logic               freeFound;
  logic [IDX_W-1:0]   victim;

  // lowest-index empty slot
  always_comb begin
    freeFound = 1'b0;
    freeIdx   = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!slotValid[i]) begin
        freeFound = 1'b1;
        freeIdx   = IDX_W'(i);
      end
    end
  end

  assign victim = freeFound ? freeIdx : rrPtr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rrPtr <= '0;
    end else if (fillEn && !freeFound) begin
      rrPtr <= (rrPtr == LAST_IDX) ? '0 : rrPtr + 1'b1;
    end
  end

  for (genvar g = 0; g < ENTRIES; g++) begin : gSlot
    assign slotMatch[g] = slotValid[g] && (slotVpn[g] == lookVpn);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        slotValid[g] <= 1'b0;
        slotVpn[g]   <= '0;
        slotPpn[g]   <= '0;
      end else if (fillEn && (victim == IDX_W'(g))) begin
        slotValid[g] <= 1'b1;
        slotVpn[g]   <= fillVpn;
        slotPpn[g]   <= fillPpn;
      end
    end
  end

  assign hit = |slotMatch;

  always_comb begin
    hitPpn = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (slotMatch[i]) hitPpn = hitPpn | slotPpn[i];
    end
  end

endmodule

// File: rtl/pw_ctrl.sv
module pw_ctrl
  import pw_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        tlbHit,
  input  logic        memRspValid,
  output logic        reqReady,
  output logic        memReqValid,
  output ctrlStrobe_t strobe
);
  walkState_t stateQ, stateD;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end

  always_comb begin
    stateD      = stateQ;
    strobe      = '0;
    reqReady    = 1'b0;
    memReqValid = 1'b0;
    unique case (stateQ)
      ST_IDLE: begin
        reqReady = 1'b1;
        if (reqValid) begin
          strobe.latchReq = 1'b1;
          if (tlbHit) strobe.hitResp = 1'b1;
          else        stateD = ST_L1REQ;
        end
      end
      ST_L1REQ: begin
        memReqValid = 1'b1;
        stateD      = ST_L1WAIT;
      end
      ST_L1WAIT: begin
        if (memRspValid) begin
          strobe.takeL1 = 1'b1;
          stateD        = ST_L2REQ;
        end
      end
      ST_L2REQ: begin
        memReqValid  = 1'b1;
        strobe.selL2 = 1'b1;
        stateD       = ST_L2WAIT;
      end
      ST_L2WAIT: begin
        if (memRspValid) begin
          strobe.takeL2 = 1'b1;
          stateD        = ST_IDLE;
        end
      end
      default: stateD = ST_IDLE;
    endcase
  end

endmodule

// File: rtl/pw_datapath.sv
module pw_datapath
  import pw_pkg::*;
#(
  parameter int VA_W        = 20,
  parameter int PA_W        = 20,
  parameter int L1_BITS     = 2,
  parameter int L2_BITS     = 2,
  parameter int ENTRY_W     = 32,
  parameter int PTE_BYTES   = 4,
  parameter int TLB_ENTRIES = 4,
  parameter logic [PA_W-1:0] BASE_RESET = 'h01000
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrobe_t        strobe,
  input  logic [VA_W-1:0]    reqVaddr,
  input  logic               baseWe,
  input  logic [PA_W-1:0]    baseData,
  input  logic [ENTRY_W-1:0] memRspData,
  output logic               tlbHit,
  output logic [PA_W-1:0]    memReqAddr,
  output logic               respValid,
  output logic [PA_W-1:0]    respPaddr
);
  localparam int VPN_W = L1_BITS + L2_BITS;
  localparam int OFF_W = VA_W - VPN_W;
  localparam int PPN_W = PA_W - OFF_W;
  localparam int SHIFT = $clog2(PTE_BYTES);

  logic [VA_W-1:0]  vaddrQ;
  logic [PA_W-1:0]  baseQ;
  logic [PA_W-1:0]  l2BaseQ;
  logic [PA_W-1:0]  l1Addr;
  logic [PA_W-1:0]  l2Addr;
  logic [PPN_W-1:0] hitPpn;
  logic [PPN_W-1:0] walkPpn;
  logic             unusedRspBits;

  assign unusedRspBits = ^memRspData[ENTRY_W-1:PA_W];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vaddrQ  <= '0;
      baseQ   <= BASE_RESET;
      l2BaseQ <= '0;
    end else begin
      if (strobe.latchReq) vaddrQ  <= reqVaddr;
      if (baseWe)          baseQ   <= baseData;
      if (strobe.takeL1)   l2BaseQ <= memRspData[PA_W-1:0];
    end
  end

  assign l1Addr = baseQ   + (PA_W'(vaddrQ[VA_W-1 -: L1_BITS]) << SHIFT);
  assign l2Addr = l2BaseQ + (PA_W'(vaddrQ[OFF_W +: L2_BITS]) << SHIFT);
  assign memReqAddr = strobe.selL2 ? l2Addr : l1Addr;
  assign walkPpn = memRspData[OFF_W +: PPN_W];

  pw_tlb #(
    .ENTRIES (TLB_ENTRIES),
    .VPN_W   (VPN_W),
    .PPN_W   (PPN_W)
  ) u_tlb (
    .clk     (clk),
    .rstN    (rstN),
    .lookVpn (reqVaddr[VA_W-1 -: VPN_W]),
    .hit     (tlbHit),
    .hitPpn  (hitPpn),
    .fillEn  (strobe.takeL2),
    .fillVpn (vaddrQ[VA_W-1 -: VPN_W]),
    .fillPpn (walkPpn)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      respValid <= 1'b0;
      respPaddr <= '0;
    end else begin
      respValid <= strobe.hitResp || strobe.takeL2;
      if (strobe.hitResp)
        respPaddr <= {hitPpn, reqVaddr[OFF_W-1:0]};
      else if (strobe.takeL2)
        respPaddr <= {walkPpn, vaddrQ[OFF_W-1:0]};
    end
  end

endmodule

// File: rtl/pagewalk_xlate.sv
module pagewalk_xlate
  import pw_pkg::*;
#(
  parameter int VA_W        = 20,
  parameter int PA_W        = 20,
  parameter int L1_BITS     = 2,
  parameter int L2_BITS     = 2,
  parameter int ENTRY_W     = 32,
  parameter int PTE_BYTES   = 4,
  parameter int TLB_ENTRIES = 4,
  parameter logic [PA_W-1:0] BASE_RESET = 'h01000
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               reqValid,
  output logic               reqReady,
  input  logic [VA_W-1:0]    reqVaddr,
  input  logic               baseWe,
  input  logic [PA_W-1:0]    baseData,
  output logic               respValid,
  output logic [PA_W-1:0]    respPaddr,
  output logic               memReqValid,
  output logic [PA_W-1:0]    memReqAddr,
  input  logic               memRspValid,
  input  logic [ENTRY_W-1:0] memRspData
);
  ctrlStrobe_t strobe;
  logic        tlbHit;

  pw_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .reqValid    (reqValid),
    .tlbHit      (tlbHit),
    .memRspValid (memRspValid),
    .reqReady    (reqReady),
    .memReqValid (memReqValid),
    .strobe      (strobe)
  );

  pw_datapath #(
    .VA_W        (VA_W),
    .PA_W        (PA_W),
    .L1_BITS     (L1_BITS),
    .L2_BITS     (L2_BITS),
    .ENTRY_W     (ENTRY_W),
    .PTE_BYTES   (PTE_BYTES),
    .TLB_ENTRIES (TLB_ENTRIES),
    .BASE_RESET  (BASE_RESET)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .reqVaddr   (reqVaddr),
    .baseWe     (baseWe),
    .baseData   (baseData),
    .memRspData (memRspData),
    .tlbHit     (tlbHit),
    .memReqAddr (memReqAddr),
    .respValid  (respValid),
    .respPaddr  (respPaddr)
  );

endmodule

// File: rtl/pagewalk_xlate_chk.sv
module pagewalk_xlate_chk #(
  parameter int VA_W      = 20,
  parameter int PA_W      = 20,
  parameter int L1_BITS   = 2,
  parameter int L2_BITS   = 2,
  parameter int PTE_BYTES = 4,
  parameter logic [PA_W-1:0] BASE_RESET = 'h01000
) (
  input logic            clk,
  input logic            rstN,
  input logic            reqValid,
  input logic            reqReady,
  input logic [VA_W-1:0] reqVaddr,
  input logic            baseWe,
  input logic [PA_W-1:0] baseData,
  input logic            respValid,
  input logic [PA_W-1:0] respPaddr,
  input logic            memReqValid,
  input logic [PA_W-1:0] memReqAddr,
  input logic            memRspValid
);
  localparam int OFF_W = VA_W - L1_BITS - L2_BITS;
  localparam int SHIFT = $clog2(PTE_BYTES);

  logic            outstanding;
  logic            secondRead;
  logic [PA_W-1:0] baseMirror;
  logic [VA_W-1:0] vaMirror;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outstanding <= 1'b0;
      secondRead  <= 1'b0;
      baseMirror  <= BASE_RESET;
      vaMirror    <= '0;
    end else begin
      if (memReqValid)      outstanding <= 1'b1;
      else if (memRspValid) outstanding <= 1'b0;
      if (memReqValid)      secondRead  <= ~secondRead;
      if (baseWe)           baseMirror  <= baseData;
      if (reqValid && reqReady) vaMirror <= reqVaddr;
    end
  end

  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid |-> !outstanding); // R8

  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rstN)
    outstanding |-> !reqReady); // R12

  AST_ACCEPT_ADVANCES: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> (respValid || memReqValid)); // R7

  AST_L1_ADDR: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && !secondRead) |->
      (memReqAddr == baseMirror + (PA_W'(vaMirror[VA_W-1 -: L1_BITS]) << SHIFT))); // R3

  AST_PA_OFFSET: assert property (@(posedge clk) disable iff (!rstN)
    respValid |-> (respPaddr[OFF_W-1:0] == vaMirror[OFF_W-1:0])); // R6

  AST_RESP_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    respValid |-> ($past(reqValid && reqReady) || $past(memRspValid))); // R7

endmodule

bind pagewalk_xlate pagewalk_xlate_chk #(
  .VA_W       (VA_W),
  .PA_W       (PA_W),
  .L1_BITS    (L1_BITS),
  .L2_BITS    (L2_BITS),
  .PTE_BYTES  (PTE_BYTES),
  .BASE_RESET (BASE_RESET)
) u_chk (.*);

// File: tb/pagewalk_xlate_tb.sv
`timescale 1ns/1ps
module pagewalk_xlate_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [19:0] reqVaddr = '0;
  logic        baseWe = 1'b0;
  logic [19:0] baseData = '0;
  logic        respValid;
  logic [19:0] respPaddr;
  logic        memReqValid;
  logic [19:0] memReqAddr;
  logic        memRspValid = 1'b0;
  logic [31:0] memRspData = '0;

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  pagewalk_xlate u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqVaddr(reqVaddr), .baseWe(baseWe), .baseData(baseData),
    .respValid(respValid), .respPaddr(respPaddr),
    .memReqValid(memReqValid), .memReqAddr(memReqAddr),
    .memRspValid(memRspValid), .memRspData(memRspData)
  );

  localparam logic [19:0] BASE0 = 20'h01000;
  localparam logic [19:0] BASE1 = 20'h05000;

  function automatic logic [19:0] l2Base(input int tbl, input int idx);
    return 20'h20000 + 20'(tbl) * 20'h10000 + 20'(idx) * 20'h400;
  endfunction

  function automatic logic [3:0] expPpn(input int tbl, input int vpn);
    return 4'((vpn * 7 + 3 + tbl * 5) & 15);
  endfunction

  // memory image computed from address
  function automatic logic [31:0] memWord(input logic [19:0] a);
    for (int t = 0; t < 2; t++) begin
      for (int i = 0; i < 4; i++) begin
        if (a == ((t == 0) ? BASE0 : BASE1) + 20'(i * 4))
          return {12'hF5A, l2Base(t, i)};
        for (int j = 0; j < 4; j++)
          if (a == l2Base(t, i) + 20'(j * 4))
            return {12'h3C5, expPpn(t, i * 4 + j), 16'(a * 13)};
      end
    end
    return 32'h0;
  endfunction

  // memory model with latency 0..2 extra cycles
  int          memReads = 0;
  logic [19:0] addrLast = '0, addrPrev = '0;
  logic        pend = 1'b0;
  logic [19:0] pAddr = '0;
  int          pCnt = 0;

  always @(posedge clk) begin
    memRspValid <= 1'b0;
    if (memReqValid) begin
      pend     <= 1'b1;
      pAddr    <= memReqAddr;
      pCnt     <= memReads % 3;
      memReads <= memReads + 1;
      addrPrev <= addrLast;
      addrLast <= memReqAddr;
    end else if (pend) begin
      if (pCnt == 0) begin
        memRspValid <= 1'b1;
        memRspData  <= memWord(pAddr);
        pend        <= 1'b0;
      end else begin
        pCnt <= pCnt - 1;
      end
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  // one translation with full checking
  task automatic xl(input int vpn, input logic [15:0] off, input int tbl,
                    input bit expHit, input string tag);
    int          startReads;
    int          lat;
    int          reads;
    bit          busyOk;
    logic [19:0] exp;
    exp = {expPpn(tbl, vpn), off};
    @(negedge clk);
    startReads = memReads;
    reqValid = 1'b1;
    reqVaddr = {4'(vpn), off};
    @(posedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    reqVaddr = 20'hAAAAA;
    lat = 1;
    busyOk = 1'b1;
    while (!respValid && lat < 200) begin
      if (reqReady) busyOk = 1'b0;
      @(negedge clk);
      lat++;
    end
    reads = memReads - startReads;
    check(respValid && respPaddr == exp, "R6 R5 R2 physical address", respPaddr, exp);
    if (expHit) begin
      check(reads == 0, {tag, " hit makes no memory read (R7)"}, reads, 0);
      check(lat == 1, "R7 hit latency", lat, 1);
    end else begin
      check(reads == 2, {tag, " miss makes two reads (R8)"}, reads, 2);
      check(addrPrev == ((tbl == 0) ? BASE0 : BASE1) + 20'((vpn >> 2) * 4),
            "R3 level-1 read address", addrPrev,
            ((tbl == 0) ? BASE0 : BASE1) + 20'((vpn >> 2) * 4));
      check(addrLast == l2Base(tbl, vpn >> 2) + 20'((vpn & 3) * 4),
            "R4 level-2 read address", addrLast,
            l2Base(tbl, vpn >> 2) + 20'((vpn & 3) * 4));
      check(busyOk, "R12 not ready during walk", {31'b0, busyOk}, 1);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    doReset();
    // R1 reset state
    check(reqReady == 1'b1, "R1 reqReady after reset", reqReady, 1);
    check(respValid == 1'b0, "R1 respValid after reset", respValid, 0);
    check(memReqValid == 1'b0, "R1 memReqValid after reset", memReqValid, 0);

    // sweep every page: miss then hit with a different offset (R2 R9)
    for (int v = 0; v < 16; v++) begin
      xl(v, 16'(v * 16'h1111 + 16'h0F0), 0, 1'b0, "R9");
      xl(v, 16'(16'hFFFF - v * 16'h0777), 0, 1'b1, "R9");
    end

    // replacement order from a clean cache (R9 R10)
    doReset();
    for (int v = 0; v < 4; v++) xl(v, 16'h1234, 0, 1'b0, "R9");
    for (int v = 0; v < 4; v++) xl(v, 16'h0001, 0, 1'b1, "R9");
    xl(4, 16'h8000, 0, 1'b0, "R10");        // evicts slot 0 (page 0)
    for (int v = 1; v < 5; v++) xl(v, 16'h00FF, 0, 1'b1, "R10");
    xl(0, 16'h4321, 0, 1'b0, "R10");        // evicts slot 1 (page 1)
    xl(2, 16'h0002, 0, 1'b1, "R10");
    xl(3, 16'h0003, 0, 1'b1, "R10");
    xl(4, 16'h0004, 0, 1'b1, "R10");
    xl(0, 16'h0005, 0, 1'b1, "R10");
    xl(1, 16'h0006, 0, 1'b0, "R10");        // evicts slot 2 (page 2)
    xl(2, 16'h0007, 0, 1'b0, "R10");        // evicts slot 3 (page 3)
    xl(3, 16'h0008, 0, 1'b0, "R10");        // evicts slot 0 (page 4)
    xl(0, 16'h0009, 0, 1'b1, "R10");
    xl(1, 16'h000A, 0, 1'b1, "R10");

    // base register reload (R11)
    doReset();
    @(negedge clk);
    baseWe = 1'b1;
    baseData = BASE1;
    @(negedge clk);
    baseWe = 1'b0;
    baseData = '0;
    for (int v = 5; v < 16; v += 3) begin
      xl(v, 16'(v * 16'h0321), 1, 1'b0, "R11");
      xl(v, 16'hBEEF, 1, 1'b1, "R11");
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule